// File: doc/BRIEF.md
# SPI FIFO Pacing Unit

This unit sits between the system bus and the serial shifter of an SPI master and owns both data queues. Bus writes of one, two or four bytes fill the transmit queue, and the shifter draws from it in units of the channel width. The shifter deposits received units into the receive queue, and the bus drains it in bus-width words. Each queue holds 64 bytes, so a wide bus word may carry several narrow channel units, or the other way round.

Each direction raises a request when its queue crosses a programmable byte threshold. By default that request is an interrupt line. When the direction's DMA enable is set, the request goes to a DMA line instead, paced for single transfers or for four-transfer bursts. Bytes left in the receive queue below the threshold are not stranded. An idle timer, reloaded on every receive write, starts a flush once it expires. The flush offers the leftover bytes to the bus, as a partial word if need be, until the queue is empty.

The shifter, the clock generator and the register decode sit outside this unit. They connect through plain valid/ready ports and one configuration write strobe.

Top module: `spi_fifo_pacer`

## Requirements
- R1: Width codes map as 2'b00 = 1 byte, 2'b01 = 2 bytes and 2'b10 = 4 bytes. A configuration write that carries 2'b11 in a width field leaves that field unchanged. Reset clears every configuration field to 0, which gives byte widths, levels of 0, interrupt mode and single transfers.
- R2: A transmit bus write stores only the low bus-width bytes of `tx_wdata`, least significant byte first. The shifter port presents them in the same order, one channel-width unit at a time, in the low bits of `tx_ch_data` with zeros above.
- R3: Received channel units are stored in arrival order, low byte first. `rx_rvalid` rises once a full bus word is held, and `rx_rdata` presents that word with its earliest byte in bits 7:0.
- R4: Each queue holds 64 bytes. `tx_wready` is low when fewer than bus-width bytes are free, and `rx_ch_ready` is low when fewer than channel-width bytes are free.
- R5: With receive DMA disabled, `rx_irq` is high when the receive byte count is non-zero and at least the receive level, or while a flush is active. `rx_dma_req` stays low in this mode.
- R6: With transmit DMA disabled, `tx_irq` is high when the transmit byte count is at or below the transmit level. `tx_dma_req` stays low in this mode.
- R7: With a direction's DMA enable set, its interrupt stays low and its DMA request carries the condition. In single mode (burst bit 0) the DMA request also needs at least one bus word held (receive) or free (transmit).
- R8: In burst mode (burst bit 1) the DMA request needs four bus words held (receive) or four bus words free (transmit). The exception is an active receive flush, which raises the receive request on its own.
- R9: Every receive write reloads the idle timer with the trailing count T. While the queue is non-empty and below the level, the flush starts T+1 cycles after the last write. During the flush, `rx_rvalid` offers the leftover bytes with zeros above them. The flush ends when the queue is empty.
- R10: The four request outputs are registered. Each one reflects the queue and configuration state one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_chan_w | input | 2 | Channel width code |
| cfg_bus_w | input | 2 | Bus width code |
| cfg_trail | input | 10 | Receive idle cycles before flush |
| cfg_rx_lvl | input | 6 | Receive threshold in bytes |
| cfg_tx_lvl | input | 6 | Transmit threshold in bytes |
| cfg_rx_dma | input | 1 | Receive DMA enable |
| cfg_tx_dma | input | 1 | Transmit DMA enable |
| cfg_burst | input | 1 | 0 single, 1 four-transfer burst |
| tx_wvalid | input | 1 | Bus write to transmit queue |
| tx_wdata | input | 32 | Bus write data |
| tx_wready | output | 1 | Room for one bus word |
| tx_ch_valid | output | 1 | Channel unit available for shifter |
| tx_ch_data | output | 32 | Channel unit, low-aligned |
| tx_ch_ready | input | 1 | Shifter takes the unit |
| rx_ch_valid | input | 1 | Shifter delivers a unit |
| rx_ch_data | input | 32 | Received unit, low-aligned |
| rx_ch_ready | output | 1 | Room for one channel unit |
| rx_rvalid | output | 1 | Bus word (or flush remainder) available |
| rx_rdata | output | 32 | Receive read data |
| rx_rready | input | 1 | Bus takes the word |
| rx_irq | output | 1 | Receive interrupt request |
| tx_irq | output | 1 | Transmit interrupt request |
| rx_dma_req | output | 1 | Receive DMA request |
| tx_dma_req | output | 1 | Transmit DMA request |

## Verification
On every cycle, the assertions check three things. Neither queue overflows or underflows, and a reserved width code never alters the stored width. An interrupt and a DMA request never fire together, and a burst-mode DMA request never rises without four words of room or data unless a flush is active. The flush always ends once the receive queue is empty. Only the bench scenarios show the rest: the byte order through packing and unpacking, the exact cycle on which the idle timer expires after a reload, and the threshold boundaries in each mode.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;
  localparam int LANES = 4;
  localparam int DW    = 8 * LANES;

  localparam logic [1:0] WC_BYTE = 2'b00;
  localparam logic [1:0] WC_HALF = 2'b01;
  localparam logic [1:0] WC_RSVD = 2'b11;

  // byte count of a width code
  function automatic logic [2:0] width_bytes(input logic [1:0] code);
    case (code)
      WC_BYTE: return 3'd1;
      WC_HALF: return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  // mask keeping the low n byte lanes
  function automatic logic [DW-1:0] lane_mask(input logic [2:0] n);
    logic [DW-1:0] m;
    for (int i = 0; i < LANES; i++)
      m[8*i +: 8] = (i < int'(n)) ? 8'hFF : 8'h00;
    return m;
  endfunction
endpackage

// File: rtl/spi_byte_fifo.sv
module spi_byte_fifo #(
  parameter int DEPTH = 64,
  parameter int LANES = 4,
  parameter int NW    = $clog2(LANES) + 1,
  parameter int CW    = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [NW-1:0]    push_n,
  input  logic [8*LANES-1:0] push_data,
  input  logic             pop,
  input  logic [NW-1:0]    pop_n,
  output logic [8*LANES-1:0] pop_data,
  output logic [CW-1:0]    count
);
  localparam int AW = $clog2(DEPTH);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [NW-1:0] in_n, out_n;

  assign in_n  = push ? push_n : '0;
  assign out_n = pop  ? pop_n  : '0;

  always_ff @(posedge clk) begin
    if (push)
      for (int i = 0; i < LANES; i++)
        if (i < int'(push_n)) mem[wp + AW'(i)] <= push_data[8*i +: 8];
  end

  always_comb begin
    for (int i = 0; i < LANES; i++) pop_data[8*i +: 8] = mem[rp + AW'(i)];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      wp    <= wp + AW'(in_n);
      rp    <= rp + AW'(out_n);
      count <= count + CW'(in_n) - CW'(out_n);
    end
  end

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    push |-> (CW'(DEPTH) - count) >= CW'(push_n));
  // R4
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    pop |-> count >= CW'(pop_n));
  // R4
  count_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!push && !pop) |=> $stable(count));
endmodule

// File: rtl/spi_trail_timer.sv
module spi_trail_timer #(
  parameter int TW    = 10,
  parameter int LVL_W = 6,
  parameter int CW    = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [TW-1:0]    trail,
  input  logic [CW-1:0]    count,
  input  logic [LVL_W-1:0] level,
  output logic             flush
);
  logic [TW-1:0] cnt;
  logic          armed;

  assign armed = (count != '0) && (count < CW'(level)) && !flush;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      flush <= 1'b0;
    end else begin
      if (load)
        cnt <= trail;
      else if (armed) begin
        if (cnt == '0) flush <= 1'b1;
        else           cnt   <= cnt - 1'b1;
      end
      if (count == '0 && !load) flush <= 1'b0;
    end
  end

  // R9
  flush_end_chk: assert property (@(posedge clk) disable iff (rst)
    (count == '0 && !load) |=> !flush);
  // R9
  no_rise_on_load_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> !$rose(flush));
endmodule

// File: rtl/spi_req_gen.sv
module spi_req_gen #(
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] avail,
  input  logic [2:0]    unit_n,
  input  logic          level_ok,
  input  logic          flush,
  input  logic          dma_en,
  input  logic          burst,
  output logic          irq,
  output logic          dma
);
  logic [CW-1:0] need;
  logic          room_ok;

  assign need    = burst ? CW'({unit_n, 2'b00}) : CW'(unit_n);
  assign room_ok = avail >= need;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq <= 1'b0;
      dma <= 1'b0;
    end else begin
      irq <= !dma_en && (level_ok || flush);
      dma <= dma_en && ((level_ok && room_ok) || flush);
    end
  end

  // R7
  one_path_chk: assert property (@(posedge clk) disable iff (rst)
    !(irq && dma));
  // R8
  burst_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (dma_en && burst && avail < CW'({unit_n, 2'b00}) && !flush) |=> !dma);
endmodule

// File: rtl/spi_fifo_pacer.sv
module spi_fifo_pacer
  import spi_fifo_pkg::*;
#(
  parameter int FIFO_BYTES = 64,
  parameter int LVL_W      = 6,
  parameter int TRAIL_W    = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_we,
  input  logic [1:0]         cfg_chan_w,
  input  logic [1:0]         cfg_bus_w,
  input  logic [TRAIL_W-1:0] cfg_trail,
  input  logic [LVL_W-1:0]   cfg_rx_lvl,
  input  logic [LVL_W-1:0]   cfg_tx_lvl,
  input  logic               cfg_rx_dma,
  input  logic               cfg_tx_dma,
  input  logic               cfg_burst,
  input  logic               tx_wvalid,
  input  logic [DW-1:0]      tx_wdata,
  output logic               tx_wready,
  output logic               tx_ch_valid,
  output logic [DW-1:0]      tx_ch_data,
  input  logic               tx_ch_ready,
  input  logic               rx_ch_valid,
  input  logic [DW-1:0]      rx_ch_data,
  output logic               rx_ch_ready,
  output logic               rx_rvalid,
  output logic [DW-1:0]      rx_rdata,
  input  logic               rx_rready,
  output logic               rx_irq,
  output logic               tx_irq,
  output logic               rx_dma_req,
  output logic               tx_dma_req
);
  localparam int CW = $clog2(FIFO_BYTES) + 1;

  logic [1:0]         chan_q, bus_q;
  logic [TRAIL_W-1:0] trail_q;
  logic [LVL_W-1:0]   rx_lvl_q, tx_lvl_q;
  logic               rx_dma_q, tx_dma_q, burst_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chan_q   <= WC_BYTE;
      bus_q    <= WC_BYTE;
      trail_q  <= '0;
      rx_lvl_q <= '0;
      tx_lvl_q <= '0;
      rx_dma_q <= 1'b0;
      tx_dma_q <= 1'b0;
      burst_q  <= 1'b0;
    end else if (cfg_we) begin
      if (cfg_chan_w != WC_RSVD) chan_q <= cfg_chan_w;
      if (cfg_bus_w  != WC_RSVD) bus_q  <= cfg_bus_w;
      trail_q  <= cfg_trail;
      rx_lvl_q <= cfg_rx_lvl;
      tx_lvl_q <= cfg_tx_lvl;
      rx_dma_q <= cfg_rx_dma;
      tx_dma_q <= cfg_tx_dma;
      burst_q  <= cfg_burst;
    end
  end

  // R1
  rsvd_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_chan_w == WC_RSVD) |=> $stable(chan_q));

  logic [2:0]    chan_n, bus_n, rd_n;
  logic [CW-1:0] tx_cnt, rx_cnt, tx_free, rx_free;
  logic [DW-1:0] tx_raw, rx_raw;
  logic          tx_push, tx_pop, rx_push, rx_pop, rx_word, rx_flush;
  logic          rx_lvl_ok, tx_lvl_ok;

  assign chan_n  = width_bytes(chan_q);
  assign bus_n   = width_bytes(bus_q);
  assign tx_free = CW'(FIFO_BYTES) - tx_cnt;
  assign rx_free = CW'(FIFO_BYTES) - rx_cnt;

  // transmit side: bus words in, channel units out
  assign tx_wready   = tx_free >= CW'(bus_n);
  assign tx_push     = tx_wvalid && tx_wready;
  assign tx_ch_valid = tx_cnt >= CW'(chan_n);
  assign tx_pop      = tx_ch_valid && tx_ch_ready;
  assign tx_ch_data  = tx_raw & lane_mask(chan_n);

  // receive side: channel units in, bus words (or flush remainder) out
  assign rx_ch_ready = rx_free >= CW'(chan_n);
  assign rx_push     = rx_ch_valid && rx_ch_ready;
  assign rx_word     = rx_cnt >= CW'(bus_n);
  assign rx_rvalid   = rx_word || (rx_flush && rx_cnt != '0);
  assign rd_n        = rx_word ? bus_n : rx_cnt[2:0];
  assign rx_pop      = rx_rvalid && rx_rready;
  assign rx_rdata    = rx_raw & lane_mask(rd_n);

  assign rx_lvl_ok = (rx_cnt != '0) && (rx_cnt >= CW'(rx_lvl_q));
  assign tx_lvl_ok = tx_cnt <= CW'(tx_lvl_q);

  spi_byte_fifo #(.DEPTH(FIFO_BYTES), .LANES(LANES), .NW(3), .CW(CW)) u_tx_fifo (
    .clk(clk), .rst(rst),
    .push(tx_push), .push_n(bus_n), .push_data(tx_wdata),
    .pop(tx_pop), .pop_n(chan_n), .pop_data(tx_raw),
    .count(tx_cnt)
  );

  spi_byte_fifo #(.DEPTH(FIFO_BYTES), .LANES(LANES), .NW(3), .CW(CW)) u_rx_fifo (
    .clk(clk), .rst(rst),
    .push(rx_push), .push_n(chan_n), .push_data(rx_ch_data),
    .pop(rx_pop), .pop_n(rd_n), .pop_data(rx_raw),
    .count(rx_cnt)
  );

  spi_trail_timer #(.TW(TRAIL_W), .LVL_W(LVL_W), .CW(CW)) u_trail (
    .clk(clk), .rst(rst), .load(rx_push), .trail(trail_q),
    .count(rx_cnt), .level(rx_lvl_q), .flush(rx_flush)
  );

  spi_req_gen #(.CW(CW)) u_rx_req (
    .clk(clk), .rst(rst), .avail(rx_cnt), .unit_n(bus_n),
    .level_ok(rx_lvl_ok), .flush(rx_flush), .dma_en(rx_dma_q), .burst(burst_q),
    .irq(rx_irq), .dma(rx_dma_req)
  );

  spi_req_gen #(.CW(CW)) u_tx_req (
    .clk(clk), .rst(rst), .avail(tx_free), .unit_n(bus_n),
    .level_ok(tx_lvl_ok), .flush(1'b0), .dma_en(tx_dma_q), .burst(burst_q),
    .irq(tx_irq), .dma(tx_dma_req)
  );
endmodule

// File: tb/spi_fifo_pacer_bench.sv
module spi_fifo_pacer_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic        cfg_we = 0, cfg_rx_dma = 0, cfg_tx_dma = 0, cfg_burst = 0;
  logic [1:0]  cfg_chan_w = 0, cfg_bus_w = 0;
  logic [9:0]  cfg_trail = 0;
  logic [5:0]  cfg_rx_lvl = 0, cfg_tx_lvl = 0;
  logic        tx_wvalid = 0, tx_ch_ready = 1, rx_ch_valid = 0, rx_rready = 0;
  logic [31:0] tx_wdata = 0, rx_ch_data = 0;
  logic        tx_wready, tx_ch_valid, rx_ch_ready, rx_rvalid;
  logic [31:0] tx_ch_data, rx_rdata;
  logic        rx_irq, tx_irq, rx_dma_req, tx_dma_req;

  spi_fifo_pacer u_spi_fifo_pacer (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_chan_w(cfg_chan_w), .cfg_bus_w(cfg_bus_w),
    .cfg_trail(cfg_trail), .cfg_rx_lvl(cfg_rx_lvl), .cfg_tx_lvl(cfg_tx_lvl),
    .cfg_rx_dma(cfg_rx_dma), .cfg_tx_dma(cfg_tx_dma), .cfg_burst(cfg_burst),
    .tx_wvalid(tx_wvalid), .tx_wdata(tx_wdata), .tx_wready(tx_wready),
    .tx_ch_valid(tx_ch_valid), .tx_ch_data(tx_ch_data), .tx_ch_ready(tx_ch_ready),
    .rx_ch_valid(rx_ch_valid), .rx_ch_data(rx_ch_data), .rx_ch_ready(rx_ch_ready),
    .rx_rvalid(rx_rvalid), .rx_rdata(rx_rdata), .rx_rready(rx_rready),
    .rx_irq(rx_irq), .tx_irq(tx_irq), .rx_dma_req(rx_dma_req), .tx_dma_req(tx_dma_req)
  );

  int n_chk = 0, n_bad = 0;
  int cb = 1, bb = 1;
  bit done = 0;
  logic [31:0] exp_q[$];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // scoreboard monitor on the shifter side (R2)
  always @(posedge clk) begin
    if (!rst && tx_ch_valid && tx_ch_ready) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R2 unexpected unit: actual %h expected none", tx_ch_data);
      end else begin
        chk("R2 tx unit", tx_ch_data, exp_q.pop_front());
      end
    end
  end

  task automatic cfg(input logic [1:0] ch, input logic [1:0] bw, input logic [9:0] tr,
                     input logic [5:0] rl, input logic [5:0] tl,
                     input logic rd, input logic td, input logic bu);
    cfg_chan_w = ch; cfg_bus_w = bw; cfg_trail = tr; cfg_rx_lvl = rl; cfg_tx_lvl = tl;
    cfg_rx_dma = rd; cfg_tx_dma = td; cfg_burst = bu; cfg_we = 1;
    @(negedge clk);
    cfg_we = 0;
  endtask

  function automatic logic [31:0] lowmask(input int n);
    return (n >= 4) ? 32'hFFFF_FFFF : ((32'h1 << (8 * n)) - 1);
  endfunction

  task automatic tx_write(input logic [31:0] w);
    chk("R4 tx room", tx_wready, 1'b1);
    tx_wvalid = 1; tx_wdata = w;
    @(negedge clk);
    tx_wvalid = 0;
    for (int k = 0; k < bb / cb; k++) exp_q.push_back((w >> (8 * cb * k)) & lowmask(cb));
  endtask

  task automatic tx_drain();
    for (int k = 0; k < 500 && exp_q.size() != 0; k++) @(negedge clk);
    repeat (2) @(negedge clk);
    chk("R2 all units seen", exp_q.size(), 0);
  endtask

  task automatic rx_push(input logic [31:0] w);
    rx_ch_valid = 1; rx_ch_data = w;
    @(negedge clk);
    rx_ch_valid = 0;
  endtask

  task automatic rx_read(input string req, input logic [31:0] exp);
    chk(req, rx_rvalid, 1'b1);
    chk(req, rx_rdata, exp);
    rx_rready = 1;
    @(negedge clk);
    rx_rready = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // reset state (R1, R10)
    chk("R10 reset rx_irq", rx_irq, 0);
    chk("R10 reset tx_irq", tx_irq, 0);
    chk("R1 reset rvalid", rx_rvalid, 0);
    chk("R1 reset tx_ch_valid", tx_ch_valid, 0);
    @(negedge clk);
    chk("R6 empty at level 0", tx_irq, 1);
    chk("R5 empty no rx_irq", rx_irq, 0);

    // R2 packing, byte channel on word bus
    cfg(2'b00, 2'b10, 0, 0, 0, 0, 0, 0); cb = 1; bb = 4;
    tx_write(32'h4433_2211);
    tx_drain();
    cfg(2'b01, 2'b10, 0, 0, 0, 0, 0, 0); cb = 2; bb = 4;
    tx_write(32'h8877_6655);
    tx_drain();
    // R1 reserved channel code keeps halfword
    cfg(2'b11, 2'b01, 0, 0, 0, 0, 0, 0); cb = 2; bb = 2;
    tx_write(32'h1234_BBAA);
    tx_drain();
    // R1 reserved bus code keeps halfword
    cfg(2'b00, 2'b11, 0, 0, 0, 0, 0, 0); cb = 1; bb = 2;
    tx_write(32'h5678_DDCC);
    tx_drain();

    // R4 / R6 full transmit queue
    cfg(2'b00, 2'b10, 0, 0, 8, 0, 0, 0); cb = 1; bb = 4;
    tx_ch_ready = 0;
    for (int k = 0; k < 16; k++) tx_write(32'h0101_0101 * (k + 1));
    chk("R4 tx full", tx_wready, 0);
    @(negedge clk);
    chk("R6 above level", tx_irq, 0);
    tx_ch_ready = 1;
    tx_drain();
    chk("R6 drained", tx_irq, 1);

    // R3 / R5 / R10 receive threshold
    cfg(2'b00, 2'b10, 5, 4, 8, 0, 0, 0);
    rx_push(32'hFFFF_FFA1); rx_push(32'hFFFF_FFA2); rx_push(32'hFFFF_FFA3);
    chk("R3 partial not valid", rx_rvalid, 0);
    chk("R5 below level", rx_irq, 0);
    rx_push(32'hFFFF_FFA4);
    chk("R3 word valid", rx_rvalid, 1);
    chk("R10 irq lags", rx_irq, 0);
    @(negedge clk);
    chk("R5 at level", rx_irq, 1);
    rx_read("R3 word order", 32'hA4A3_A2A1);

    // R9 reload and flush timing (T = 5)
    rx_push(32'h0000_00B1);
    repeat (3) @(negedge clk);
    rx_push(32'h0000_00B2);
    repeat (5) @(negedge clk);
    chk("R9 reload delays flush", rx_rvalid, 0);
    @(negedge clk);
    chk("R9 flush starts", rx_rvalid, 1);
    @(negedge clk);
    chk("R9 flush irq", rx_irq, 1);
    rx_read("R9 flush remainder", 32'h0000_B2B1);
    repeat (3) @(negedge clk);
    chk("R9 flush ended", rx_rvalid, 0);
    chk("R9 irq cleared", rx_irq, 0);

    // R3 halfword channel into word bus
    cfg(2'b01, 2'b10, 1023, 4, 8, 0, 0, 0);
    rx_push(32'hFFFF_3231); rx_push(32'hFFFF_3433);
    rx_read("R3 halfword pack", 32'h3433_3231);

    // R7 receive DMA single
    cfg(2'b00, 2'b10, 1023, 2, 8, 1, 0, 0);
    rx_push(32'hC1); rx_push(32'hC2);
    repeat (2) @(negedge clk);
    chk("R7 single needs a word", rx_dma_req, 0);
    chk("R7 irq off in dma", rx_irq, 0);
    rx_push(32'hC3); rx_push(32'hC4);
    @(negedge clk);
    chk("R7 single dma", rx_dma_req, 1);
    chk("R7 irq off in dma", rx_irq, 0);
    rx_read("R7 dma data", 32'hC4C3_C2C1);
    repeat (2) @(negedge clk);
    chk("R7 dma drops", rx_dma_req, 0);

    // R8 receive DMA burst
    cfg(2'b00, 2'b10, 1023, 4, 8, 1, 0, 1);
    for (int k = 0; k < 8; k++) rx_push(32'h10 + k);
    repeat (2) @(negedge clk);
    chk("R8 burst needs four words", rx_dma_req, 0);
    for (int k = 8; k < 16; k++) rx_push(32'h10 + k);
    @(negedge clk);
    chk("R8 burst ready", rx_dma_req, 1);
    rx_read("R8 burst w0", 32'h1312_1110);
    rx_read("R8 burst w1", 32'h1716_1514);
    rx_read("R8 burst w2", 32'h1B1A_1918);
    rx_read("R8 burst w3", 32'h1F1E_1D1C);

    // R8 flush overrides burst gating
    cfg(2'b00, 2'b10, 3, 8, 8, 1, 0, 1);
    rx_push(32'h21); rx_push(32'h22); rx_push(32'h23);
    repeat (10) @(negedge clk);
    chk("R8 flush raises dma", rx_dma_req, 1);
    rx_read("R8 flush data", 32'h0023_2221);
    repeat (3) @(negedge clk);
    chk("R8 flush done", rx_dma_req, 0);

    // R7 / R8 transmit DMA
    cfg(2'b00, 2'b10, 0, 0, 63, 0, 1, 1); cb = 1; bb = 4;
    tx_ch_ready = 0;
    repeat (2) @(negedge clk);
    chk("R8 tx burst room", tx_dma_req, 1);
    chk("R7 tx irq off", tx_irq, 0);
    for (int k = 0; k < 13; k++) tx_write(32'h5000_0000 + k);
    @(negedge clk);
    chk("R8 tx burst lacks room", tx_dma_req, 0);
    cfg(2'b00, 2'b10, 0, 0, 63, 0, 1, 0);
    repeat (2) @(negedge clk);
    chk("R7 tx single room", tx_dma_req, 1);
    for (int k = 0; k < 3; k++) tx_write(32'h6000_0000 + k);
    @(negedge clk);
    chk("R7 tx single full", tx_dma_req, 0);
    tx_ch_ready = 1;
    tx_drain();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule